// File: doc/BRIEF.md
# Display Control and DMA Request Unit

This block keeps the 32-bit status word and the display control registers of a graphics engine. A CPU reaches it through two 32-bit register slots: the command/data slot at byte offset 0 and the control/status slot at byte offset 4. Control writes carry an 8-bit opcode in bits 31:24 and a 24-bit argument in bits 23:0. These writes load the display start address, the horizontal and vertical display ranges, the DMA direction and the display mode fields of the status word. Data-slot writes are not interpreted here. They are forwarded on a command stream output for a downstream command assembler.

A 16-entry readback queue holds words that a producer (for example a frame-memory reader) pushes in. The CPU drains it by reading offset 0. A DMA engine drains it through a dedicated DMA read port. The unit drives a DMA request line, chosen by a two-bit direction field in the status word. Reads of an empty queue, DMA transfers in the wrong direction, unmapped offsets and unknown opcodes all have defined, harmless outcomes.

Top module: `disp_ctl_unit`

## Requirements
- R1: After reset the status word reads 0x14802000, the horizontal range output is 0xC60260, the vertical range output is 0x3FC10, the display start address is 0, the direction is 0 and the overflow flag is clear.
- R2: A control write with opcode 0x05 loads argument bits 18:0 into the display start address. Opcode 0x06 loads all 24 argument bits into the horizontal range. Opcode 0x07 loads argument bits 19:0 into the vertical range. Each takes effect on the following cycle.
- R3: Opcode 0x08 copies argument bits into the status word as follows: 1:0 to bits 17:16, 2 to bit 19, 3 to bit 20, 4 to bit 21, 5 to bit 22, 6 to bit 18 and 7 to bit 14. No other status bit changes.
- R4: Opcode 0x04 sets the direction, held in status bits 30:29, from argument bits 1:0. The DMA request (also status bit 25) is 0 for direction 0 and 1 for direction 1. For direction 2 it follows ready-to-receive, and for direction 3 it follows ready-to-send.
- R5: Status bit 27 (ready-to-send) is 1 exactly when the readback queue is non-empty. Bits 26 (ready for command) and 28 (ready for DMA input) are 1 exactly when it is empty.
- R6: A register read at offset 0 returns the oldest queued word and removes it. When the queue is empty, the read returns 0xFFFFFFFF and changes nothing.
- R7: The queue holds 16 words in order. A push while it holds 16 words, with no pop in the same cycle, is dropped and sets a sticky overflow flag that only reset clears. A push and a pop in the same cycle on a full queue both take effect.
- R8: A DMA read returns the oldest queued word and removes it only when the direction is 3 and the queue is non-empty. Otherwise it returns 0xFFFFFFFF and changes nothing.
- R9: A register write at offset 0 appears on the command stream in the same cycle. A DMA write appears there only when the direction is 2.
- R10: Opcode 0x01 raises the command-discard pulse for the cycle of the write, and for no other write.
- R11: Reads at any offset other than 0 or 4 return 0xFFFFFFFF. Writes there, and control writes with an unlisted opcode, change no register output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| dma_rd | input | 1 | DMA read strobe |
| dma_rdata | output | 32 | DMA read data, valid in the strobe cycle |
| dma_wr | input | 1 | DMA write strobe |
| dma_wdata | input | 32 | DMA write data |
| dma_req | output | 1 | DMA request |
| rb_push | input | 1 | Producer push into the readback queue |
| rb_data | input | 32 | Word being pushed |
| cmd_valid | output | 1 | Command stream word valid |
| cmd_data | output | 32 | Command stream word |
| cmd_discard | output | 1 | Discard partly assembled command |
| status_word | output | 32 | Live status word |
| disp_start | output | 19 | Display start address |
| hrange | output | 24 | Horizontal display range |
| vrange | output | 20 | Vertical display range |
| rb_overflow | output | 1 | Sticky readback overflow flag |

## Verification
The bench attacks the queue boundaries: draining to empty and then reading again, filling to exactly 16 words, pushing a 17th word, and pushing and popping together while full. A design with an off-by-one depth, or one that refuses the push on a full queue with a pop in the same cycle, loses or duplicates a word, and the reference queue catches the difference. All four directions are exercised with DMA reads and writes in each. This exposes a request mux wired to the wrong flag, and DMA traffic that leaks through in a direction that should block it. Opcode 0x08 is driven with walking single bits, so a swapped field lands in the wrong status bit. Unlisted opcodes and unmapped offsets are checked against unchanged register outputs.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam logic [31:0] STAT_INIT = 32'h1480_2000;
  localparam logic [23:0] HR_INIT   = 24'hC6_0260;
  localparam logic [19:0] VR_INIT   = 20'h3_FC10;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;

  typedef enum logic [7:0] {
    OP_DISCARD = 8'h01,
    OP_DIR     = 8'h04,
    OP_START   = 8'h05,
    OP_HRANGE  = 8'h06,
    OP_VRANGE  = 8'h07,
    OP_MODE    = 8'h08
  } ctl_op_e;

  typedef enum logic [1:0] {
    DIR_OFF  = 2'd0,
    DIR_ON   = 2'd1,
    DIR_IN   = 2'd2,
    DIR_OUT  = 2'd3
  } dma_dir_e;

  // Request line chosen by the direction field
  function automatic logic req_select(input logic [1:0] dir, input logic q_empty);
    case (dir)
      DIR_OFF: req_select = 1'b0;
      DIR_ON:  req_select = 1'b1;
      DIR_IN:  req_select = q_empty;
      default: req_select = !q_empty;
    endcase
  endfunction

  // Live status: stored bits with the queue flags, request and direction overlaid
  function automatic logic [31:0] build_status(input logic [31:0] base,
                                               input logic [1:0] dir,
                                               input logic q_empty);
    logic [31:0] s;
    s        = base;
    s[30:29] = dir;
    s[28]    = q_empty;
    s[27]    = !q_empty;
    s[26]    = q_empty;
    s[25]    = req_select(dir, q_empty);
    return s;
  endfunction

  // Display mode argument folded into the stored status bits
  function automatic logic [31:0] apply_mode(input logic [31:0] base, input logic [23:0] arg);
    logic [31:0] s;
    s        = base;
    s[17:16] = arg[1:0];
    s[19]    = arg[2];
    s[20]    = arg[3];
    s[21]    = arg[4];
    s[22]    = arg[5];
    s[18]    = arg[6];
    s[14]    = arg[7];
    return s;
  endfunction
endpackage

// File: rtl/dcu_readback_q.sv
module dcu_readback_q #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          overflow
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_pop, do_push, drop_evt;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign do_pop   = pop && !empty;
  assign do_push  = push && (!full || do_pop);
  assign drop_evt = push && full && !do_pop;
  assign head     = mem[rp];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (drop_evt) overflow <= 1'b1;
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow);
  a_r7_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n) drop_evt |=> overflow);
  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dcu_ctl_regs.sv
module dcu_ctl_regs
  import dcu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] stat_base,
  output logic [1:0]  dir,
  output logic [18:0] disp_start,
  output logic [23:0] hrange,
  output logic [19:0] vrange,
  output logic        discard
);
  logic [7:0]  op;
  logic [23:0] arg;

  assign op      = ctl_wdata[31:24];
  assign arg     = ctl_wdata[23:0];
  assign discard = ctl_we && (op == OP_DISCARD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_base  <= STAT_INIT;
      dir        <= DIR_OFF;
      disp_start <= '0;
      hrange     <= HR_INIT;
      vrange     <= VR_INIT;
    end else if (ctl_we) begin
      case (op)
        OP_DIR:    dir        <= arg[1:0];
        OP_START:  disp_start <= arg[18:0];
        OP_HRANGE: hrange     <= arg;
        OP_VRANGE: vrange     <= arg[19:0];
        OP_MODE:   stat_base  <= apply_mode(stat_base, arg);
        default:   ;
      endcase
    end
  end

  a_r2_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(disp_start) && $stable(hrange) && $stable(vrange));
  a_r3_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_base[13:0] == $past(stat_base[13:0])) && (stat_base[31:23] == $past(stat_base[31:23])));
  a_r4_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_we && op == OP_DIR) |=> $stable(dir));
endmodule

// File: rtl/disp_ctl_unit.sv
module disp_ctl_unit
  import dcu_pkg::*;
#(
  parameter int unsigned RB_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_off,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dma_rd,
  output logic [31:0] dma_rdata,
  input  logic        dma_wr,
  input  logic [31:0] dma_wdata,
  output logic        dma_req,
  input  logic        rb_push,
  input  logic [31:0] rb_data,
  output logic        cmd_valid,
  output logic [31:0] cmd_data,
  output logic        cmd_discard,
  output logic [31:0] status_word,
  output logic [18:0] disp_start,
  output logic [23:0] hrange,
  output logic [19:0] vrange,
  output logic        rb_overflow
);
  localparam logic [7:0] OFF_DATA = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h04;

  logic        hit_data, hit_ctrl, ctl_we;
  logic        reg_pop, dma_pop, q_empty;
  logic [31:0] q_head, stat_base;
  logic [1:0]  dir;

  assign hit_data = (reg_off == OFF_DATA);
  assign hit_ctrl = (reg_off == OFF_CTRL);
  assign ctl_we   = reg_wr && hit_ctrl;
  assign reg_pop  = reg_rd && hit_data;
  assign dma_pop  = dma_rd && (dir == DIR_OUT);

  dcu_readback_q #(.DEPTH(RB_DEPTH), .DW(WORD_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(rb_push), .push_data(rb_data),
    .pop(reg_pop || dma_pop), .head(q_head), .empty(q_empty), .overflow(rb_overflow)
  );

  dcu_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(reg_wdata),
    .stat_base(stat_base), .dir(dir), .disp_start(disp_start),
    .hrange(hrange), .vrange(vrange), .discard(cmd_discard)
  );

  assign status_word = build_status(stat_base, dir, q_empty);
  assign dma_req     = req_select(dir, q_empty);

  always_comb begin
    reg_rdata = ALL_ONES;
    if (reg_rd && hit_data && !q_empty) reg_rdata = q_head;
    else if (reg_rd && hit_ctrl)        reg_rdata = status_word;
  end

  assign dma_rdata = (dma_pop && !q_empty) ? q_head : ALL_ONES;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_data  = '0;
    if (reg_wr && hit_data) begin
      cmd_valid = 1'b1;
      cmd_data  = reg_wdata;
    end else if (dma_wr && dir == DIR_IN) begin
      cmd_valid = 1'b1;
      cmd_data  = dma_wdata;
    end
  end

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[27] != status_word[26]);
  a_r4_req_in_status: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req == status_word[25]);
  a_r8_wrong_dir_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd && dir != DIR_OUT) |=> $stable(status_word[27]) || $past(rb_push) || $past(reg_rd));
  a_r9_dma_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && !reg_wr && dir != DIR_IN) |-> !cmd_valid);
endmodule

// File: tb/sim_disp_ctl_unit.sv
`timescale 1ns/100ps
module sim_disp_ctl_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, dma_rd = 0, dma_wr = 0, rb_push = 0;
  logic [7:0] reg_off = 0;
  logic [31:0] reg_wdata = 0, dma_wdata = 0, rb_data = 0;
  logic [31:0] reg_rdata, dma_rdata, cmd_data, status_word;
  logic dma_req, cmd_valid, cmd_discard, rb_overflow;
  logic [18:0] disp_start;
  logic [23:0] hrange;
  logic [19:0] vrange;

  always #2.5 clk = ~clk;

  disp_ctl_unit u0 (.*);

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] q[$];
  logic [31:0] m_base;
  logic [1:0] m_dir;
  logic [18:0] m_ds;
  logic [23:0] m_hr;
  logic [19:0] m_vr;
  logic m_ovf;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic m_req();
    bit e = (q.size() == 0);
    case (m_dir)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return e;
      default: return !e;
    endcase
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] s = m_base;
    bit e = (q.size() == 0);
    s[30:29] = m_dir; s[28] = e; s[27] = !e; s[26] = e; s[25] = m_req();
    return s;
  endfunction

  task automatic compare_state();
    chk(status_word == m_status(), "R3/R4/R5 status", status_word, m_status());
    chk(dma_req == m_req(), "R4 dma_req", 32'(dma_req), 32'(m_req()));
    chk(disp_start == m_ds && hrange == m_hr && vrange == m_vr, "R2/R11 ranges",
        {hrange, 8'h0}, {m_hr, 8'h0});
    chk(rb_overflow == m_ovf, "R7 overflow", 32'(rb_overflow), 32'(m_ovf));
  endtask

  // One clock: drive at negedge, check combinational outputs, advance model at the edge
  task automatic step(input bit rw, input bit rr, input logic [7:0] off, input logic [31:0] wd,
                      input bit dr, input bit dw, input logic [31:0] dwd,
                      input bit ps, input logic [31:0] pd);
    bit e, pop;
    logic [31:0] exp_r, exp_d;
    @(negedge clk);
    reg_wr = rw; reg_rd = rr; reg_off = off; reg_wdata = wd;
    dma_rd = dr; dma_wr = dw; dma_wdata = dwd; rb_push = ps; rb_data = pd;
    #1;
    e = (q.size() == 0);
    if (rr) begin
      exp_r = 32'hFFFF_FFFF;
      if (off == 0 && !e) exp_r = q[0];
      else if (off == 4) exp_r = m_status();
      chk(reg_rdata === exp_r, "R6/R11 reg read", reg_rdata, exp_r);
    end
    if (dr) begin
      exp_d = (m_dir == 3 && !e) ? q[0] : 32'hFFFF_FFFF;
      chk(dma_rdata === exp_d, "R8 dma read", dma_rdata, exp_d);
    end
    chk(cmd_valid == ((rw && off == 0) || (dw && m_dir == 2)), "R9 cmd_valid", 32'(cmd_valid), 32'(rw));
    if (rw && off == 0) chk(cmd_data == wd, "R9 cmd_data", cmd_data, wd);
    else if (dw && m_dir == 2) chk(cmd_data == dwd, "R9 cmd_data dma", cmd_data, dwd);
    chk(cmd_discard == (rw && off == 4 && wd[31:24] == 8'h01), "R10 discard", 32'(cmd_discard), wd);
    @(posedge clk);
    pop = !e && ((rr && off == 0) || (dr && m_dir == 3));
    if (pop) void'(q.pop_front());
    if (ps) begin
      if (q.size() < 16) q.push_back(pd); else m_ovf = 1;
    end
    if (rw && off == 4) begin
      case (wd[31:24])
        8'h04: m_dir = wd[1:0];
        8'h05: m_ds = wd[18:0];
        8'h06: m_hr = wd[23:0];
        8'h07: m_vr = wd[19:0];
        8'h08: begin
          m_base[17:16] = wd[1:0]; m_base[19] = wd[2]; m_base[20] = wd[3];
          m_base[21] = wd[4]; m_base[22] = wd[5]; m_base[18] = wd[6]; m_base[14] = wd[7];
        end
        default: ;
      endcase
    end
    #1 compare_state();
    reg_wr = 0; reg_rd = 0; dma_rd = 0; dma_wr = 0; rb_push = 0;
  endtask

  task automatic ctl(input logic [31:0] w); step(1, 0, 8'h04, w, 0, 0, 0, 0, 0); endtask
  task automatic push(input logic [31:0] d); step(0, 0, 0, 0, 0, 0, 0, 1, d); endtask
  task automatic rd(input logic [7:0] off); step(0, 1, off, 0, 0, 0, 0, 0, 0); endtask
  task automatic drd(); step(0, 0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic dwr(input logic [31:0] d); step(0, 0, 0, 0, 0, 1, d, 0, 0); endtask

  initial begin
    m_base = 32'h1480_2000; m_dir = 0; m_ds = 0; m_hr = 24'hC60260; m_vr = 20'h3FC10; m_ovf = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(status_word == 32'h1480_2000, "R1 status reset", status_word, 32'h1480_2000);
    chk(hrange == 24'hC60260 && vrange == 20'h3FC10 && disp_start == 0, "R1 ranges reset",
        {8'h0, hrange}, 32'hC60260);
    @(negedge clk) rst_n = 1;
    rd(8'h04);
    rd(8'h00);                                   // R6 empty read
    push(32'hA1); push(32'hB2); push(32'hC3);
    rd(8'h04); rd(8'h00); rd(8'h00);
    ctl(32'h0400_0003);                          // R8 direction 3
    drd(); drd();                                // second on empty
    for (int d = 0; d < 4; d++) begin            // R4 R8 R9 in every direction, empty and not
      ctl(32'h0400_0000 | d);
      dwr(32'h5500_0000 | d); drd();
      push(32'h100 + d);
      dwr(32'h6600_0000 | d); drd(); rd(8'h00);
    end
    ctl(32'h0400_0001);
    for (int i = 0; i < 16; i++) push(32'h200 + i);  // R7 fill to 16
    push(32'hDEAD);                              // overflow
    step(0, 1, 8'h00, 0, 0, 0, 0, 1, 32'hBEEF);  // full pop+push
    push(32'hF00D);
    for (int i = 0; i < 17; i++) rd(8'h00);
    ctl(32'h0512_3456); ctl(32'h06AB_CDEF); ctl(32'h07FF_FFFF);   // R2
    for (int b = 0; b < 8; b++) ctl(32'h0800_0000 | (1 << b));    // R3 walking bits
    ctl(32'h0800_00FF); ctl(32'h0800_0000);
    ctl(32'h0900_FFFF); ctl(32'h0300_1234);      // R11 unknown opcodes
    step(1, 0, 8'h08, 32'h0612_3456, 0, 0, 0, 0, 0);  // R11 unmapped write
    rd(8'h08); rd(8'hFC);
    ctl(32'h0100_0000);                          // R10
    step(1, 0, 8'h00, 32'hE100_0001, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule